// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Timer

This block decides, in the digital clock domain, when the power switch of a quasi-resonant flyback converter is switched on again. Each turn-on starts a fixed blanking interval in which no new turn-on may occur. When blanking ends, the block either searches a bounded window for a valley of the drain ringing (seen through a comparator on the auxiliary winding) or, if the winding is still high at that moment, waits a fixed delay instead. If no valley qualifies before the window closes, a turn-on is forced. Together these rules keep the switching period between a lower and an upper bound.

The two comparator inputs are asynchronous to the clock and pass through a synchronizer of `SYNC_STAGES` flops before use. A select input picks turn-on at the first or the second valley found in the window. All durations are parameters in clock cycles. The single output is a one-cycle turn-on request to the gate-drive logic. Turn-off, current sensing and the analog comparators lie outside the block.

Top module: `qr_valley_timer`

## Requirements
- R1: While `rst_ni` is low, `turn_on_o` is 0. With `en_i` high, the first clock edge that samples `en_i` high while the block is idle (after reset or after a disable) makes `turn_on_o` high for the following cycle.
- R2: `turn_on_o` is never high in two consecutive cycles.
- R3: A rising edge of `valley_cmp_i` that reaches the control logic at any of the first `BLANK_CYC` edges after a turn-on causes no turn-on. The next turn-on is never earlier than `BLANK_CYC`+1 cycles after the previous one.
- R4: With `valley_sel_i` = 0 (first valley), a rising edge of `valley_cmp_i` sampled by a clock edge X gives a turn-on at edge X+`SYNC_STAGES`, provided that edge lies between `BLANK_CYC`+1 and `BLANK_CYC`+`WINDOW_CYC` cycles after the previous turn-on.
- R5: If no valley qualifies and the flat case does not apply, a turn-on is forced exactly `BLANK_CYC`+`WINDOW_CYC` cycles after the previous one.
- R6: If `flat_cmp_i` (after synchronization) is 1 at the edge that ends blanking (edge `BLANK_CYC` after the turn-on), the next turn-on comes exactly `BLANK_CYC`+`FLAT_DLY_CYC` cycles after the previous one, and valley edges in between have no effect.
- R7: With `valley_sel_i` = 1 (second valley), the first qualifying valley edge in the window causes no turn-on; the second one gives a turn-on with the R4 timing; with fewer than two, R5 applies.
- R8: While `en_i` is sampled low, no turn-on is issued and all timing state returns to idle; on re-enable, timing restarts from a fresh turn-on per R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low stops switching and clears timing state |
| valley_cmp_i | input | 1 | Comparator: winding voltage below the valley threshold (asynchronous) |
| flat_cmp_i | input | 1 | Comparator: winding voltage above the flat-level threshold (asynchronous) |
| valley_sel_i | input | 1 | 0 = turn on at first valley, 1 = at second valley |
| turn_on_o | output | 1 | One-cycle switch turn-on request |

## Verification
The assertions assume `en_i` and `valley_sel_i` are synchronous to the clock and that each valley shows up as a comparator level held high for at least one clock after crossing. The stimulus drives every input at the falling clock edge, holds `valley_sel_i` constant through each period, and shapes each valley as a one-cycle high level with at least one low cycle between valleys, so every rising edge survives the synchronizer as a distinct event. Valley and flat-level timings are swept across each cycle offset from just after a turn-on to past the window end, so every ignored, accepted and forced case is reached.

// File: rtl/qr_pkg.sv
package qr_pkg;

   typedef enum logic [1:0] {
      QS_IDLE  = 2'd0,
      QS_BLANK = 2'd1,
      QS_WIN   = 2'd2,
      QS_FLAT  = 2'd3
   } qr_state_e;

   function automatic int unsigned qr_max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned qr_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
      return qr_max2(qr_max2(a, b), c);
   endfunction

endpackage

// File: rtl/qr_sync_chain.sv
module qr_sync_chain #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_clk_rst;
         assign unused_clk_rst = clk_i ^ rst_ni;
         assign q_o = d_i;
      end else begin : g_flops
         logic [STAGES-1:0][WIDTH-1:0] pipe_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               pipe_q <= '0;
            end else begin
               pipe_q[0] <= d_i;
               for (int i = 1; i < int'(STAGES); i++) begin
                  pipe_q[i] <= pipe_q[i-1];
               end
            end
         end
         assign q_o = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/qr_rise_det.sv
module qr_rise_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic rise_o
);

   logic prev_q;

   // Previous level resets high so a comparator already high at reset
   // does not look like a fresh edge.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= d_i;
   end

   assign rise_o = d_i & ~prev_q;

endmodule

// File: rtl/qr_interval_cnt.sv
module qr_interval_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + CNT_W'(1);
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == (limit_i - CNT_W'(1)));

   AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_i |-> (cnt_q < (limit_i - CNT_W'(1))))
      else $error("interval counter stepped past its limit"); // R5

endmodule

// File: rtl/qr_valley_timer.sv
module qr_valley_timer
   import qr_pkg::*;
#(
   parameter int unsigned BLANK_CYC    = 1500,
   parameter int unsigned WINDOW_CYC   = 600,
   parameter int unsigned FLAT_DLY_CYC = 250,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic valley_cmp_i,
   input  logic flat_cmp_i,
   input  logic valley_sel_i,
   output logic turn_on_o
);

   localparam int unsigned MAX_LIM = qr_max3(BLANK_CYC, WINDOW_CYC, FLAT_DLY_CYC);
   localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);
   localparam int unsigned MAX_GAP = BLANK_CYC + qr_max2(WINDOW_CYC, FLAT_DLY_CYC);
   localparam int unsigned GAP_W   = $clog2(MAX_GAP + 2);

   localparam logic [CNT_W-1:0] LIM_BLANK = CNT_W'(BLANK_CYC);
   localparam logic [CNT_W-1:0] LIM_WIN   = CNT_W'(WINDOW_CYC);
   localparam logic [CNT_W-1:0] LIM_FLAT  = CNT_W'(FLAT_DLY_CYC);

   initial begin : p_param_check
      assert (BLANK_CYC >= 1)    else $error("BLANK_CYC must be at least 1");
      assert (WINDOW_CYC >= 1)   else $error("WINDOW_CYC must be at least 1");
      assert (FLAT_DLY_CYC >= 1) else $error("FLAT_DLY_CYC must be at least 1");
   end

   // Comparator synchronization: bit 0 valley, bit 1 flat level
   logic [1:0] cmp_s;
   logic       valley_edge;

   qr_sync_chain #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    ({flat_cmp_i, valley_cmp_i}),
      .q_o    (cmp_s)
   );

   qr_rise_det i_rise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cmp_s[0]),
      .rise_o (valley_edge)
   );

   // Interval counter shared by blanking, window and flat delay
   qr_state_e        st_q, st_d;
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt;
   logic             cnt_last, cnt_clr, cnt_inc;
   logic             seen_q, seen_d;
   logic             fire;
   logic             pulse_q;

   always_comb begin
      unique case (st_q)
         QS_BLANK: limit = LIM_BLANK;
         QS_WIN:   limit = LIM_WIN;
         QS_FLAT:  limit = LIM_FLAT;
         default:  limit = LIM_BLANK;
      endcase
   end

   qr_interval_cnt #(
      .CNT_W (CNT_W)
   ) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (cnt_clr),
      .inc_i   (cnt_inc),
      .limit_i (limit),
      .cnt_o   (cnt),
      .last_o  (cnt_last)
   );

   logic unused_cnt;
   assign unused_cnt = ^cnt;

   // Next-state logic
   always_comb begin
      st_d    = st_q;
      seen_d  = seen_q;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      fire    = 1'b0;
      if (!en_i) begin
         st_d    = QS_IDLE;
         seen_d  = 1'b0;
         cnt_clr = 1'b1;
      end else begin
         unique case (st_q)
            QS_IDLE: begin
               fire = 1'b1;
            end
            QS_BLANK: begin
               if (cnt_last) begin
                  cnt_clr = 1'b1;
                  seen_d  = 1'b0;
                  st_d    = cmp_s[1] ? QS_FLAT : QS_WIN;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            QS_WIN: begin
               if (valley_edge && (!valley_sel_i || seen_q)) begin
                  fire = 1'b1;
               end else if (cnt_last) begin
                  fire = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
                  if (valley_edge) seen_d = 1'b1;
               end
            end
            QS_FLAT: begin
               if (cnt_last) fire    = 1'b1;
               else          cnt_inc = 1'b1;
            end
            default: st_d = QS_IDLE;
         endcase
         if (fire) begin
            st_d    = QS_BLANK;
            cnt_clr = 1'b1;
            seen_d  = 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= QS_IDLE;
         seen_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         seen_q  <= seen_d;
         pulse_q <= fire;
      end
   end

   assign turn_on_o = pulse_q;

   // Checker state: cycles since the last turn-on
   logic [GAP_W-1:0] gap_q;
   logic             armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (turn_on_o)                         gap_q <= GAP_W'(1);
         else if (gap_q != GAP_W'(MAX_GAP + 1)) gap_q <= gap_q + GAP_W'(1);
         if (!en_i)          armed_q <= 1'b0;
         else if (turn_on_o) armed_q <= 1'b1;
      end
   end

   AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      turn_on_o |=> !turn_on_o)
      else $error("turn-on request longer than one cycle"); // R2

   AST_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !turn_on_o)
      else $error("turn-on issued while disabled"); // R8

   AST_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (turn_on_o && armed_q) |-> (gap_q >= GAP_W'(BLANK_CYC + 1)))
      else $error("turn-on inside blanking"); // R3

   AST_MAX_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (armed_q && !turn_on_o) |-> (gap_q < GAP_W'(MAX_GAP)))
      else $error("turn-on overdue"); // R5

   AST_FIRST_VALLEY_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && st_q == QS_WIN && valley_edge && !valley_sel_i) |=> turn_on_o)
      else $error("window valley did not trigger turn-on"); // R4

endmodule

// File: tb/test_qr_valley_timer.sv
module test_qr_valley_timer;

   localparam int CLK_PERIOD = 10;
   localparam int B = 6;
   localparam int W = 4;
   localparam int D = 2;
   localparam int S = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic vcmp = 1'b0;
   logic fcmp = 1'b0;
   logic vsel = 1'b0;
   logic ton;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   qr_valley_timer #(
      .BLANK_CYC    (B),
      .WINDOW_CYC   (W),
      .FLAT_DLY_CYC (D),
      .SYNC_STAGES  (S)
   ) i_qr_valley_timer (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .en_i         (en),
      .valley_cmp_i (vcmp),
      .flat_cmp_i   (fcmp),
      .valley_sel_i (vsel),
      .turn_on_o    (ton)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #(CLK_PERIOD/2);
   endtask

   function automatic bit in_win(input int a);
      return (a >= B + 1) && (a <= B + W);
   endfunction

   function automatic int exp_first(input int a);
      return in_win(a) ? a : B + W;
   endfunction

   function automatic int exp_second(input int a1, input int a2);
      return (in_win(a1) && in_win(a2)) ? a2 : B + W;
   endfunction

   // Starts at the mid-cycle of a turn-on cycle; valleys given as the
   // turn-on offset they would act at; flat_n cycles of flat level from t=0.
   task automatic period(input int a1, input int a2, input int flat_n, input bit sec,
                         output int got);
      got = -1;
      vsel = sec;
      for (int t = 0; t < 60; t++) begin
         if (t > 0 && ton) begin
            got = t;
            break;
         end
         vcmp = (t == a1 - 1 - S) || (t == a2 - 1 - S);
         fcmp = (t < flat_n);
         tick();
      end
      vcmp = 1'b0;
      fcmp = 1'b0;
   endtask

   task automatic wait_pulse(output int n);
      n = -1;
      for (int t = 1; t < 60; t++) begin
         tick();
         if (ton) begin
            n = t;
            break;
         end
      end
   endtask

   task automatic quiet_span(input int n, input string req);
      int seen = 0;
      for (int t = 0; t < n; t++) begin
         tick();
         if (ton) seen++;
      end
      check(seen == 0, req, seen, 0);
   endtask

   initial begin : p_watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : p_main
      int got;
      int exp;
      string req;

      // R1: reset state
      repeat (3) tick();
      check(ton == 1'b0, "R1 reset low", int'(ton), 0);
      en = 1'b1;
      rst_n = 1'b1;
      tick();
      check(ton == 1'b1, "R1 first turn-on after enable", int'(ton), 1);

      // R2: pulse lasts one cycle; R5: forced period completes
      tick();
      check(ton == 1'b0, "R2 single-cycle pulse", int'(ton), 0);
      wait_pulse(got);
      check(got == B + W - 1, "R5 forced after empty window", got + 1, B + W);

      // R5: plain forced period
      period(0, 0, 0, 1'b0, got);
      check(got == B + W, "R5 forced turn-on", got, B + W);

      // R3/R4/R5: first-valley sweep over every offset
      for (int a = S + 1; a <= B + W + 2; a++) begin
         exp = exp_first(a);
         req = (a <= B) ? "R3 valley in blanking ignored" :
               (in_win(a) ? "R4 first valley turn-on" : "R5 late valley forced");
         period(a, 0, 0, 1'b0, got);
         check(got == exp, req, got, exp);
      end

      // R7: second-valley sweep over pairs
      for (int a1 = S + 1; a1 <= B + W + 1; a1++) begin
         for (int a2 = a1 + 2; a2 <= B + W + 2; a2++) begin
            exp = exp_second(a1, a2);
            period(a1, a2, 0, 1'b1, got);
            check(got == exp, "R7 second valley", got, exp);
         end
      end
      // R7: single valley in window under second-valley mode is skipped
      period(B + 1, 0, 0, 1'b1, got);
      check(got == B + W, "R7 lone valley skipped", got, B + W);

      // R6: flat-level sweep; flat seen at blanking end iff flat_n > B-1-S
      for (int f = 0; f <= B + 2; f++) begin
         exp = (f > B - 1 - S) ? B + D : B + W;
         period(0, 0, f, 1'b0, got);
         check(got == exp, "R6 flat level at blanking end", got, exp);
      end
      period(B + 1, 0, B, 1'b0, got);
      check(got == B + D, "R6 valley ignored in flat delay", got, B + D);
      period(B + 1, 0, B - 1 - S, 1'b0, got);
      check(got == B + 1, "R6 flat ended before decision", got, B + 1);

      // R8: disable right after a turn-on
      en = 1'b0;
      quiet_span(3 * (B + W), "R8 no turn-on while disabled");
      en = 1'b1;
      tick();
      check(ton == 1'b1, "R8 re-enable turn-on", int'(ton), 1);
      period(0, 0, 0, 1'b0, got);
      check(got == B + W, "R8 timing restarts", got, B + W);

      // R8: disable inside the window with a valley pending
      for (int t = 0; t < B; t++) begin
         vcmp = (t == B - 1 - S);
         tick();
      end
      en = 1'b0;
      vcmp = 1'b0;
      quiet_span(3 * (B + W), "R8 disable mid-window");
      en = 1'b1;
      tick();
      check(ton == 1'b1, "R8 re-enable after mid-window stop", int'(ton), 1);
      period(B + 2, 0, 0, 1'b0, got);
      check(got == B + 2, "R8 valley after restart", got, B + 2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule